// File: doc/BRIEF.md
# Two-Phase Interleaved PWM Timing Generator

This block produces the gate-timing signals for a two-channel interleaved step-down converter. One programmable cycle counter sets the switching period. From it each channel gets its own digital sawtooth ramp and its own termination instant. Channel 2 terminates exactly half a period after channel 1. Each channel's output falls at its termination. It then stays low through a blanking window of a quarter period. After that window it rises as soon as its ramp reaches a level. That level is the shared command word minus the channel's own correction word.

The control loop sets the period, the command and the two corrections. Analog sensing, gate drivers and loop compensation are outside the block. Outputs are registered. Changes to the period are held back until the next channel-1 cycle boundary, so a running cycle is never cut short or stretched.

Top module: `ilv_pwm_top`

## Requirements
- R1: The channel-1 cycle length P in clocks equals the period setting with its two least significant bits cleared. Any result below 4 is treated as 4.
- R2: On the first clock of each channel-1 cycle (channel-1 ramp value 0), `pwm1` is low.
- R3: Channel 2's ramp equals (channel-1 ramp + P/2) mod P. `pwm2` is low whenever that value is 0.
- R4: After its termination, a channel's output stays low while its ramp is below P/4, whatever the level.
- R5: Past the blanking window, a channel's output goes high on the first clock in which its ramp is greater than or equal to its level. Each ramp counts up by one per clock from 0 at its termination.
- R6: Each channel's level is max(`cmd` − its own correction, 0), computed separately per channel and clamped at zero.
- R7: Once high, an output stays high until its next termination, even if the level later rises. If the level is never reached, the output stays low for the whole cycle.
- R8: A new period setting takes effect only at a channel-1 cycle boundary. The running cycle completes with the old period.
- R9: While `rst` is high or `en` is low, both outputs are low and the cycle position is cleared. The first enabled clock is clock 1 of a fresh channel-1 cycle, with the period taken from the setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low forces idle |
| per_set | input | 12 | Period setting in clocks |
| cmd | input | 12 | Shared command word |
| corr1 | input | 12 | Channel-1 correction word |
| corr2 | input | 12 | Channel-2 correction word |
| pwm1 | output | 1 | Channel-1 output |
| pwm2 | output | 1 | Channel-2 output |

## Verification
The hardest case to reach is a period change written in the middle of a cycle. Its effect shows only one boundary later, and channel 2 keeps straddling the old and new periods. The stimulus changes `per_set` at a point unrelated to the cycle position and runs across several boundaries. The bench's own cycle model decides where each edge must fall. Correction words larger than the command drive the level to zero, which exposes the quarter-period blanking on its own. Single-clock enable drops restart the cycle from an arbitrary point.

// File: rtl/ilv_pwm_pkg.sv
package ilv_pwm_pkg;

    localparam int PER_W = 12;
    localparam int CMD_W = 12;
    localparam int NCH   = 2;

    localparam logic [PER_W-1:0] PER_MIN = PER_W'(4);

    typedef struct packed {
        logic [PER_W-1:0] ph;
        logic [PER_W-1:0] quarter;
    } phase_t;

    function automatic logic [PER_W-1:0] fold_period(input logic [PER_W-1:0] raw);
        logic [PER_W-1:0] p;
        p = {raw[PER_W-1:2], 2'b00};
        return (p < PER_MIN) ? PER_MIN : p;
    endfunction

    function automatic logic [CMD_W-1:0] floor_sub(input logic [CMD_W-1:0] a,
                                                   input logic [CMD_W-1:0] b);
        return (a > b) ? (a - b) : '0;
    endfunction

    function automatic logic reached(input logic [PER_W-1:0] ramp,
                                     input logic [CMD_W-1:0] lvl);
        return 32'(ramp) >= 32'(lvl);
    endfunction

endpackage

// File: rtl/ilv_cycle_ctr.sv
module ilv_cycle_ctr
    import ilv_pwm_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   en,
    input  logic [PER_W-1:0]       per_set,
    output logic [PER_W-1:0]       cnt_q,
    output logic [PER_W-1:0]       per_q,
    output phase_t [NCH-1:0]       ph_nxt
);

    localparam logic [PER_W-1:0] ONE = PER_W'(1);

    logic             restart;
    logic [PER_W-1:0] p_use;
    logic [PER_W-1:0] cnt_n;
    logic [PER_W-1:0] half;
    logic [PER_W-1:0] quarter;

    always_comb begin
        restart = !en || (cnt_q == per_q - ONE);
        p_use   = restart ? fold_period(per_set) : per_q;
        cnt_n   = restart ? '0 : (cnt_q + ONE);
        half    = p_use >> 1;
        quarter = p_use >> 2;
    end

    for (genvar k = 0; k < NCH; k++) begin : g_phase
        localparam bit SHIFTED = (k % 2) == 1;
        logic [PER_W:0] sum;
        logic [PER_W:0] wrapped;
        assign sum     = {1'b0, cnt_n} + (SHIFTED ? {1'b0, half} : '0);
        assign wrapped = sum - {1'b0, p_use};
        assign ph_nxt[k] = '{ph:      (sum >= {1'b0, p_use}) ? wrapped[PER_W-1:0]
                                                             : sum[PER_W-1:0],
                             quarter: quarter};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            per_q <= fold_period(per_set);
        end else begin
            cnt_q <= cnt_n;
            per_q <= p_use;
        end
    end

endmodule

// File: rtl/ilv_pwm_chan.sv
module ilv_pwm_chan
    import ilv_pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  phase_t           ph_n,
    input  logic [CMD_W-1:0] cmd,
    input  logic [CMD_W-1:0] corr,
    output logic             pwm_q
);

    logic [CMD_W-1:0] lvl;
    logic             term;
    logic             open;
    logic             hit;

    always_comb begin
        lvl  = floor_sub(cmd, corr);
        term = (ph_n.ph == '0);
        open = (ph_n.ph >= ph_n.quarter);
        hit  = reached(ph_n.ph, lvl);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            pwm_q <= 1'b0;
        end else if (term) begin
            pwm_q <= 1'b0;
        end else if (open && hit) begin
            pwm_q <= 1'b1;
        end
    end

endmodule

// File: rtl/ilv_pwm_top.sv
module ilv_pwm_top
    import ilv_pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [PER_W-1:0] per_set,
    input  logic [CMD_W-1:0] cmd,
    input  logic [CMD_W-1:0] corr1,
    input  logic [CMD_W-1:0] corr2,
    output logic             pwm1,
    output logic             pwm2
);

    logic [PER_W-1:0]  cnt_q;
    logic [PER_W-1:0]  per_q;
    phase_t [NCH-1:0]  ph_nxt;
    logic [CMD_W-1:0]  corr_v [NCH];
    logic [NCH-1:0]    pwm_v;

    assign corr_v[0] = corr1;
    assign corr_v[1] = corr2;

    ilv_cycle_ctr u_ctr (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .per_set (per_set),
        .cnt_q   (cnt_q),
        .per_q   (per_q),
        .ph_nxt  (ph_nxt)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_chan
        ilv_pwm_chan u_chan (
            .clk   (clk),
            .rst   (rst),
            .en    (en),
            .ph_n  (ph_nxt[k]),
            .cmd   (cmd),
            .corr  (corr_v[k]),
            .pwm_q (pwm_v[k])
        );
    end

    assign pwm1 = pwm_v[0];
    assign pwm2 = pwm_v[1];

endmodule

// File: rtl/ilv_pwm_chk.sv
module ilv_pwm_chk
    import ilv_pwm_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             pwm1,
    input logic             pwm2,
    input logic [PER_W-1:0] cnt_q,
    input logic [PER_W-1:0] per_q
);

    localparam logic [PER_W-1:0] ONE = PER_W'(1);
    localparam logic [PER_W-1:0] SAT = '1;

    logic             ev1, ev2;
    logic [PER_W-1:0] lo1, lo2;
    logic             arm1, arm2;

    assign ev1 = en && (cnt_q == per_q - ONE);
    assign ev2 = en && (cnt_q == (per_q >> 1) - ONE);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            lo1 <= '0; lo2 <= '0; arm1 <= 1'b0; arm2 <= 1'b0;
        end else begin
            lo1  <= ev1 ? '0 : ((lo1 == SAT) ? lo1 : lo1 + ONE);
            lo2  <= ev2 ? '0 : ((lo2 == SAT) ? lo2 : lo2 + ONE);
            arm1 <= arm1 | ev1;
            arm2 <= arm2 | ev2;
        end
    end

    p_cnt_in_range_r1: assert property (@(posedge clk) disable iff (rst)
        cnt_q < per_q);

    p_term1_low_r2: assert property (@(posedge clk) disable iff (rst)
        ev1 |=> (!pwm1 && cnt_q == '0));

    p_term2_low_r3: assert property (@(posedge clk) disable iff (rst)
        ev2 |=> !pwm2);

    p_blank1_r4: assert property (@(posedge clk) disable iff (rst)
        ($rose(pwm1) && arm1) |-> (lo1 >= (per_q >> 2)));

    p_blank2_r4: assert property (@(posedge clk) disable iff (rst)
        ($rose(pwm2) && arm2) |-> (lo2 >= (per_q >> 2)));

    p_hold_high_r7: assert property (@(posedge clk) disable iff (rst)
        (en && pwm1 && !ev1) |=> pwm1);

    p_period_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (en && !ev1) |=> $stable(per_q));

    p_idle_low_r9: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!pwm1 && !pwm2 && cnt_q == '0));

endmodule

bind ilv_pwm_top ilv_pwm_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .pwm1  (pwm1),
    .pwm2  (pwm2),
    .cnt_q (cnt_q),
    .per_q (per_q)
);

// File: tb/tb_ilv_pwm_top.sv
`timescale 1ns/1ps
module tb_ilv_pwm_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b0;
    logic [11:0] per_set = 12'd16;
    logic [11:0] cmd = '0;
    logic [11:0] corr1 = '0;
    logic [11:0] corr2 = '0;
    logic        pwm1, pwm2;

    ilv_pwm_top dut (
        .clk(clk), .rst(rst), .en(en), .per_set(per_set), .cmd(cmd),
        .corr1(corr1), .corr2(corr2), .pwm1(pwm1), .pwm2(pwm2)
    );

    always #2.5 clk = ~clk;

    int    n_vec  = 0;
    int    n_bad  = 0;
    bit    done   = 0;
    string cur    = "R9";

    bit [1:0] q_exp [$];
    string    q_t1  [$];
    string    q_t2  [$];

    int m  = 0;
    int pm = 16;
    bit e1 = 0, e2 = 0;

    function automatic int fold(input int raw);
        int p;
        p = raw & ~3;
        return (p < 4) ? 4 : p;
    endfunction

    function automatic bit step(input bit o, input int ph, input int p, input int lvl);
        if (ph == 0) return 1'b0;
        if (o) return 1'b1;
        return (ph >= p / 4) && (ph >= lvl);
    endfunction

    // Reference model: one expected vector per rising edge
    always @(posedge clk) begin
        int ph1, ph2, l1, l2;
        string t1, t2;
        t1 = cur; t2 = cur;
        if (rst || !en) begin
            m = 0; pm = fold(int'(per_set)); e1 = 0; e2 = 0;
        end else begin
            if (m == pm - 1) begin m = 0; pm = fold(int'(per_set)); end
            else m = m + 1;
            ph1 = m;
            ph2 = (m + pm / 2) % pm;
            l1 = (cmd > corr1) ? int'(cmd) - int'(corr1) : 0;
            l2 = (cmd > corr2) ? int'(cmd) - int'(corr2) : 0;
            e1 = step(e1, ph1, pm, l1);
            e2 = step(e2, ph2, pm, l2);
            if (ph1 == 0) t1 = "R2";
            if (ph2 == 0) t2 = "R3";
        end
        q_exp.push_back({e2, e1});
        q_t1.push_back(t1);
        q_t2.push_back(t2);
    end

    // Monitor: compare away from the active edge
    always @(negedge clk) begin
        bit [1:0] ex;
        string a, b;
        if (q_exp.size() != 0 && !done) begin
            ex = q_exp.pop_front(); a = q_t1.pop_front(); b = q_t2.pop_front();
            n_vec++;
            if (pwm1 !== ex[0]) begin
                n_bad++;
                $display("FAIL %s pwm1 actual=%b expected=%b at %0t", a, pwm1, ex[0], $time);
            end else if (pwm2 !== ex[1]) begin
                n_bad++;
                $display("FAIL %s pwm2 actual=%b expected=%b at %0t", b, pwm2, ex[1], $time);
            end
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive(input string tag, input int p, input int c,
                         input int k1, input int k2, input int n);
        @(negedge clk);
        cur = tag; per_set = 12'(p); cmd = 12'(c); corr1 = 12'(k1); corr2 = 12'(k2);
        run(n);
    endtask

    initial begin
        cur = "R9";
        run(5);
        @(negedge clk); rst = 1'b0;
        run(3);
        @(negedge clk); en = 1'b1;
        drive("R5", 16, 8, 0, 0, 48);              // mid-level rise
        drive("R6", 16, 10, 2, 5, 48);             // independent per-channel levels
        drive("R4", 16, 10, 20, 9, 48);            // level clamped to zero: blanking only
        drive("R7", 16, 200, 0, 0, 40);            // level never reached
        drive("R7", 16, 5, 0, 0, 13);              // rise, then level jumps up mid-cycle
        drive("R7", 16, 200, 0, 0, 20);
        drive("R1", 18, 6, 0, 0, 40);              // low bits ignored
        drive("R1", 2, 0, 0, 0, 24);               // below minimum
        drive("R1", 7, 1, 0, 3, 24);
        drive("R1", 40, 22, 4, 0, 90);
        drive("R8", 40, 30, 0, 10, 7);             // shrink mid-cycle
        drive("R8", 12, 7, 0, 2, 60);
        drive("R8", 12, 7, 0, 2, 3);
        drive("R8", 28, 15, 1, 0, 90);             // grow mid-cycle
        @(negedge clk); cur = "R9"; en = 1'b0;      // one-clock drop
        @(negedge clk); en = 1'b1;
        run(45);
        @(negedge clk); en = 1'b0;
        run(4);
        @(negedge clk); en = 1'b1;
        run(40);
        @(negedge clk); rst = 1'b1;
        run(3);
        @(negedge clk); rst = 1'b0;
        run(50);
        @(negedge clk); en = 1'b0;
        run(3);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule